// File: doc/BRIEF.md
# Datapath Pair Reconfiguration Controller

This block decides which hardware thread context drives each pair of issue slots in a polymorphic VLIW core. The core has eight datapaths grouped into four pairs and four resident contexts. A pair is the smallest unit the controller hands out. A context may own no pairs, one pair, two adjacent pairs or all four. That covers a single 8-issue machine, four 2-issue machines, and mixed splits in between.

A new mapping arrives as a 12-bit request word with a one-cycle valid strobe. The controller first checks that the mapping is legal. If it is, the controller runs a fixed nine-cycle sequence:

- For four cycles the new mapping is decoded while the old one stays live.
- For the next four cycles a flush strobe goes to every pair whose assignment changes.
- In the final cycle the new mapping goes live and a start strobe goes to each changed pair that remains enabled.

Pairs whose assignment does not change get no strobe and keep executing. Context state never leaves the core, so nothing is saved or restored.

Top module: `rcfg_top`

## Requirements
- R1: After reset, pair p is enabled and owned by context p, so map_o reads 0x688. busy_o, err_o, every flush_o bit and every start_o bit read 0.
- R2: Pair p occupies bits 3p+2 down to 3p of both req_map_i and map_o. Bit 3p+2 set means the pair is disabled. Bits 3p+1:3p give the owning context.
- R3: A request is legal when, for every context, the set of enabled pairs it owns is one of the following: empty, a single pair, pairs {0,1}, pairs {2,3}, or all four. A request that arrives while idle and is illegal raises err_o for exactly the following cycle, leaves map_o unchanged and does not raise busy_o.
- R4: A legal request that arrives while idle makes busy_o high for exactly the 9 cycles that follow the cycle in which req_valid_i was sampled.
- R5: During the first 4 busy cycles, map_o still shows the old mapping and no flush or start strobe is asserted.
- R6: During busy cycles 5 to 8, flush_o is high for exactly the changed pairs. A pair is changed when its disable bit differs between old and new, or when it is enabled in both and its owning context differs.
- R7: In busy cycle 9, map_o shows the new mapping and start_o is high for each changed pair that is enabled in the new mapping. map_o keeps the new mapping afterwards.
- R8: A pair that is unchanged never sees a flush or start strobe. A request equal to the current mapping still keeps busy_o high for 9 cycles but produces no strobes.
- R9: While busy_o is high, req_valid_i is ignored. The request is not queued, err_o stays low, and the sequence in progress finishes with its own mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | One-cycle strobe that presents a mapping request |
| req_map_i | input | 12 | Requested pair-to-context mapping, 3 bits per pair |
| map_o | output | 12 | Live pair-to-context mapping, same encoding |
| flush_o | output | 4 | Per-pair pipeline flush strobe |
| start_o | output | 4 | Per-pair strobe that starts execution under the new mapping |
| busy_o | output | 1 | A reconfiguration sequence is in progress |
| err_o | output | 1 | The previous-cycle request was illegal and was rejected |

## Verification
The assertions assume that req_map_i is stable during the cycle in which req_valid_i is high. They also assume that reset is held for at least one clock edge before any request. The stimulus drives both inputs only at falling edges and keeps reset high for several cycles at the start. Some requests are issued on purpose while busy_o is high, including in the final start cycle, to show that they are dropped. A reference model in the bench counts the sequence phase by phase and is compared with every output on every cycle.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    localparam int NUM_PAIRS  = 4;
    localparam int NUM_CTX    = 4;
    localparam int CTX_W      = $clog2(NUM_CTX);
    localparam int FIELD_W    = CTX_W + 1;
    localparam int MAP_W      = NUM_PAIRS * FIELD_W;
    localparam int DECODE_CYC = 4;
    localparam int FLUSH_CYC  = 4;
    localparam int PH_CNT_MAX = (DECODE_CYC > FLUSH_CYC) ? DECODE_CYC : FLUSH_CYC;
    localparam int CNT_W      = $clog2(PH_CNT_MAX + 1);

    typedef struct packed {
        logic             dis;
        logic [CTX_W-1:0] ctx;
    } pair_cfg_t;

    typedef pair_cfg_t [NUM_PAIRS-1:0] pair_map_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DECODE,
        PH_FLUSH,
        PH_START
    } phase_e;

    function automatic pair_map_t reset_map();
        pair_map_t m;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            m[p].dis = 1'b0;
            m[p].ctx = CTX_W'(p % NUM_CTX);
        end
        return m;
    endfunction

    function automatic logic pair_changed(input pair_cfg_t old_c, input pair_cfg_t new_c);
        return (old_c.dis != new_c.dis) || (!new_c.dis && (old_c.ctx != new_c.ctx));
    endfunction

    function automatic logic [NUM_PAIRS-1:0] ctx_owned(input pair_map_t m, input int c);
        logic [NUM_PAIRS-1:0] own;
        for (int p = 0; p < NUM_PAIRS; p++)
            own[p] = !m[p].dis && (m[p].ctx == CTX_W'(c));
        return own;
    endfunction

    // An owned set is fine when empty or an aligned power-of-two block.
    function automatic logic group_ok(input logic [NUM_PAIRS-1:0] own);
        logic                 ok;
        logic [NUM_PAIRS-1:0] pat;
        ok = (own == '0);
        for (int s = 1; s <= NUM_PAIRS; s = s * 2) begin
            for (int b = 0; b + s <= NUM_PAIRS; b = b + s) begin
                pat = '0;
                for (int k = 0; k < s; k++)
                    pat[b+k] = 1'b1;
                if (own == pat)
                    ok = 1'b1;
            end
        end
        return ok;
    endfunction

    function automatic logic map_legal(input pair_map_t m);
        logic ok;
        ok = 1'b1;
        for (int c = 0; c < NUM_CTX; c++)
            if (!group_ok(ctx_owned(m, c)))
                ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/rcfg_legal_check.sv
module rcfg_legal_check
    import rcfg_pkg::*;
(
    input  pair_map_t req_i,
    output logic      legal_o
);

    logic [NUM_CTX-1:0] ctx_ok;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [NUM_PAIRS-1:0] own;
        always_comb begin
            for (int p = 0; p < NUM_PAIRS; p++)
                own[p] = !req_i[p].dis && (req_i[p].ctx == CTX_W'(c));
        end
        assign ctx_ok[c] = group_ok(own);
    end

    assign legal_o = &ctx_ok;

endmodule

// File: rtl/rcfg_sequencer.sv
module rcfg_sequencer
    import rcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch_i,
    output phase_e phase_o,
    output logic   busy_o
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (launch_i)
                        phase_q <= PH_DECODE;
                end
                PH_DECODE: begin
                    if (cnt_q == CNT_W'(DECODE_CYC - 1)) begin
                        phase_q <= PH_FLUSH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FLUSH: begin
                    if (cnt_q == CNT_W'(FLUSH_CYC - 1)) begin
                        phase_q <= PH_START;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_START: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign busy_o  = (phase_q != PH_IDLE);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_START) |=> (phase_q == PH_IDLE)); // R4
    AST_IDLE_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !launch_i) |=> (phase_q == PH_IDLE)); // R4
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(PH_CNT_MAX)); // R4

endmodule

// File: rtl/rcfg_map_store.sv
module rcfg_map_store
    import rcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch_i,
    input  pair_map_t            req_i,
    input  phase_e               phase_i,
    output pair_map_t            map_o,
    output logic [NUM_PAIRS-1:0] flush_o,
    output logic [NUM_PAIRS-1:0] start_o
);

    pair_map_t            live_q;
    pair_map_t            pend_q;
    logic [NUM_PAIRS-1:0] chg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= reset_map();
            pend_q <= reset_map();
        end else begin
            if (launch_i)
                pend_q <= req_i;
            if (phase_i == PH_START)
                live_q <= pend_q;
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst)
                chg_q[p] <= 1'b0;
            else if (launch_i)
                chg_q[p] <= pair_changed(live_q[p], req_i[p]);
        end
        assign flush_o[p] = (phase_i == PH_FLUSH) && chg_q[p];
        assign start_o[p] = (phase_i == PH_START) && chg_q[p] && !pend_q[p].dis;
    end

    assign map_o = (phase_i == PH_START) ? pend_q : live_q;

    AST_LIVE_MOVES_AT_START: assert property (@(posedge clk) disable iff (rst)
        !$stable(live_q) |-> ($past(phase_i) == PH_START)); // R7
    AST_PEND_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (phase_i != PH_IDLE) |=> $stable(pend_q)); // R9

endmodule

// File: rtl/rcfg_top.sv
module rcfg_top
    import rcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid_i,
    input  logic [MAP_W-1:0]     req_map_i,
    output logic [MAP_W-1:0]     map_o,
    output logic [NUM_PAIRS-1:0] flush_o,
    output logic [NUM_PAIRS-1:0] start_o,
    output logic                 busy_o,
    output logic                 err_o
);

    pair_map_t req_s;
    pair_map_t map_s;
    phase_e    phase;
    logic      legal;
    logic      launch;
    logic      err_q;

    assign req_s = pair_map_t'(req_map_i);

    rcfg_legal_check u_legal (
        .req_i   (req_s),
        .legal_o (legal)
    );

    assign launch = req_valid_i && !busy_o && legal;

    rcfg_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .phase_o  (phase),
        .busy_o   (busy_o)
    );

    rcfg_map_store u_store (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .req_i    (req_s),
        .phase_i  (phase),
        .map_o    (map_s),
        .flush_o  (flush_o),
        .start_o  (start_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= req_valid_i && !busy_o && !legal;
    end

    assign err_o = err_q;
    assign map_o = MAP_W'(map_s);

    AST_ERR_KEEPS_MAP: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(map_o)); // R3
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !busy_o); // R3
    AST_MAP_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        map_legal(pair_map_t'(map_o))); // R3
    AST_FLUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|flush_o) |-> busy_o); // R6
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !((|flush_o) && (|start_o))); // R7
    AST_BUSY_REQ_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy_o && req_valid_i) |=> !err_o); // R9

endmodule

// File: tb/tb_rcfg_top.sv
`timescale 1ns/1ps
module tb_rcfg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [11:0] req_map_i = '0;
    logic [11:0] map_o;
    logic [3:0]  flush_o;
    logic [3:0]  start_o;
    logic        busy_o;
    logic        err_o;

    int checks = 0;
    int failures = 0;
    int flush_seen = 0;
    bit done = 0;

    // reference model state
    int          m_cnt = 0;
    logic [11:0] m_cur = 12'h688;
    logic [11:0] m_pend = 12'h688;
    logic [3:0]  m_chg = '0;
    logic        m_err = 1'b0;

    always #10 clk = ~clk;

    rcfg_top dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_map_i(req_map_i),
        .map_o(map_o), .flush_o(flush_o), .start_o(start_o),
        .busy_o(busy_o), .err_o(err_o)
    );

    function automatic bit is_legal(logic [11:0] m);
        for (int c = 0; c < 4; c++) begin
            int n = 0;
            int lo = -1;
            for (int p = 0; p < 4; p++)
                if (!m[3*p+2] && m[3*p +: 2] == c[1:0]) begin
                    if (lo < 0) lo = p;
                    n++;
                end
            if (n == 3) return 0;
            if (n > 0) begin
                if (lo % n != 0) return 0;
                for (int p = lo; p < lo + n; p++)
                    if (m[3*p+2] || m[3*p +: 2] != c[1:0]) return 0;
            end
        end
        return 1;
    endfunction

    function automatic logic [3:0] diff_pairs(logic [11:0] a, logic [11:0] b);
        logic [3:0] d;
        for (int p = 0; p < 4; p++)
            d[p] = (a[3*p+2] != b[3*p+2]) || (!b[3*p+2] && a[3*p +: 2] != b[3*p +: 2]);
        return d;
    endfunction

    function automatic logic [3:0] enabled(logic [11:0] m);
        logic [3:0] e;
        for (int p = 0; p < 4; p++) e[p] = !m[3*p+2];
        return e;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model();
        m_err = 1'b0;
        if (rst) begin
            m_cnt = 0; m_cur = 12'h688; m_pend = 12'h688; m_chg = '0;
        end else if (m_cnt == 9) begin
            m_cur = m_pend; m_cnt = 0;
        end else if (m_cnt != 0) begin
            m_cnt++;
        end else if (req_valid_i) begin
            if (is_legal(req_map_i)) begin
                m_pend = req_map_i; m_chg = diff_pairs(m_cur, req_map_i); m_cnt = 1;
            end else begin
                m_err = 1'b1;
            end
        end
    endtask

    task automatic compare();
        logic [11:0] e_map;
        logic [3:0]  e_fl;
        logic [3:0]  e_st;
        e_map = (m_cnt == 9) ? m_pend : m_cur;
        e_fl  = (m_cnt >= 5 && m_cnt <= 8) ? m_chg : 4'h0;
        e_st  = (m_cnt == 9) ? (m_chg & enabled(m_pend)) : 4'h0;
        if (|flush_o) flush_seen++;
        check(busy_o === (m_cnt != 0), "R4 busy", int'(busy_o), int'(m_cnt != 0));
        check(err_o === m_err, "R3 err", int'(err_o), int'(m_err));
        check(map_o === e_map, (m_cnt >= 1 && m_cnt <= 4) ? "R5 map" : "R7 map", int'(map_o), int'(e_map));
        check(flush_o === e_fl, (m_cnt <= 4) ? "R5 flush" : "R6 flush", int'(flush_o), int'(e_fl));
        check(start_o === e_st, "R7 start", int'(start_o), int'(e_st));
    endtask

    task automatic tick();
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        repeat (n) tick();
    endtask

    task automatic send(logic [11:0] m);
        req_map_i = m;
        req_valid_i = 1'b1;
        tick();
        req_valid_i = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        run(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(map_o === 12'h688 && !busy_o && !err_o && flush_o == 0 && start_o == 0,
              "R1 reset", int'(map_o), 12'h688);

        send(12'h000);          // all pairs on context 0
        run(12);
        send(12'h258);          // 1 + 2 + 0 + 1 split
        run(2);
        send(12'h688);          // R9 ignored while busy
        run(10);
        check(map_o === 12'h258, "R9 busy request dropped", int'(map_o), 12'h258);
        check(map_o[5:3] === 3'b011, "R2 pair1 field", int'(map_o[5:3]), 3);

        send(12'h648);          // R3 pairs 1,2 on one context: misaligned
        run(2);
        send(12'h608);          // R3 context 0 owns pairs 0 and 2
        run(2);
        check(map_o === 12'h258, "R3 map kept after reject", int'(map_o), 12'h258);

        flush_seen = 0;
        send(12'h258);          // R8 same mapping
        run(11);
        check(flush_seen == 0, "R8 no flush on same map", flush_seen, 0);

        send(12'h924);          // every pair disabled
        run(8);
        send(12'h000);          // R9 request in the start cycle
        run(3);
        check(map_o === 12'h924, "R9 start-cycle request dropped", int'(map_o), 12'h924);
        send(12'h688);
        run(12);
        send(12'h0C0);          // pairs 0,1 ctx0; pair2 ctx3; pair3 ctx0 -> illegal
        run(2);
        send(12'h6C0);          // pairs 0,1 ctx0; pair2 ctx3; pair3 ctx3 -> legal
        run(12);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule